// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running timer with four compare channels. A prescale counter divides the clock, so the main timer counter advances once every PR+1 enabled clocks. Each channel holds a compare value. When the timer counter equals that value on a prescaler terminal tick, the channel produces a match. For each match, per-channel control bits decide three things independently: whether an interrupt flag is latched, whether the timer counter restarts from zero, and whether counting halts.

Software reaches every register through a single-cycle register bus. A write takes effect on the clock edge where the write enable is high. Reads are combinational from the byte address. The block drives a one-cycle event pulse for each channel and a single interrupt line, which is high whenever any latched flag is set.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero. `irq` is low and all `match_pulse` bits are low.
- R2: The counters advance only while the enable bit (bit 0 of the control register at offset 0x04) is one. On each enabled clock, the prescale counter (0x10) increments. On the clock after it equals the prescale register (0x0C), it returns to zero and the timer counter (0x08) increments. As a result, the timer counter steps once every PR+1 clocks, and when the enable bit is zero both counters hold.
- R3: While bit 1 of the control register at 0x04 is one, both counters are cleared on every clock and stay at zero. This holds even when the enable bit is also one.
- R4: Channel n matches when its compare register (offset 0x18 + 4n) equals the timer counter on a prescaler terminal tick. A match drives `match_pulse[n]` high for the one clock after that tick, whatever the channel's control bits are.
- R5: When bit 3n of the match control register (0x14) is one, a match on channel n sets bit n of the flag register (0x00). `irq` is high whenever any flag bit is set.
- R6: When bit 3n+1 of 0x14 is one, a match on channel n loads the timer counter with zero instead of incrementing it. Matches on that channel then repeat every (MR+1)·(PR+1) clocks.
- R7: When bit 3n+2 of 0x14 is one, a match on channel n halts both counters and clears the enable bit of 0x04. The timer counter keeps the matched value.
- R8: Writing a one to a flag bit clears it. Writing a zero leaves the bit unchanged.
- R9: If a flag is set by a match in the same cycle that software writes one to clear it, the flag stays set.
- R10: The timer counter, prescale counter, prescale register, match control register and compare registers read back what was last written. Bits above the defined fields read as zero and ignore writes. The defined fields are bits 1:0 of 0x04, bits 11:0 of 0x14 and bits 4:0 of 0x00. Bit 4 of 0x00 is a capture placeholder that no event sets, so it reads zero. Addresses outside the map read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, applied on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| match_pulse | output | 4 | One-cycle event per channel |
| irq | output | 1 | OR of all pending flags |

## Verification
The bench goes after several timing corner cases, each of which a faulty design would visibly mishandle:

- **Divide ratio.** A design that compared the prescaler one step late would run at a PR+2 ratio.
- **Reset-on-match period.** A design that incremented before clearing would produce a period one count too long.
- **Clear-level priority.** A design that let the enable override the clear level would leak counts while bit 1 is held.
- **Self-stop.** The bench checks that a stopping channel freezes the timer counter on the matched value and drops the enable bit. A design that stopped a cycle late would show the next count.
- **Set versus clear.** The bench lands a write-one-to-clear exactly on the edge where a match sets the same flag. A design with clear priority would lose that interrupt.
- **Events without interrupts.** The bench checks that channels with interrupts disabled still pulse without touching the flags.

// File: rtl/mt_pkg.sv
// Package: shared constants and types for the prescaled match timer.
// Assumes byte addressing with 32-bit aligned registers.
package mt_pkg;
    localparam logic [7:0] OFF_FLAGS = 8'h00;
    localparam logic [7:0] OFF_CTRL  = 8'h04;
    localparam logic [7:0] OFF_TC    = 8'h08;
    localparam logic [7:0] OFF_PR    = 8'h0C;
    localparam logic [7:0] OFF_PC    = 8'h10;
    localparam logic [7:0] OFF_MCTL  = 8'h14;
    localparam logic [7:0] OFF_CMP0  = 8'h18;

    // Per-channel action bits; LSB is the interrupt enable (bit 3n).
    typedef struct packed {
        logic stop_en;
        logic zero_en;
        logic flag_en;
    } ch_cfg_t;

    // Byte offset of compare register n.
    function automatic logic [7:0] cmp_off(input int n);
        return OFF_CMP0 + 8'(4 * n);
    endfunction
endpackage

// File: rtl/mt_counters.sv
// Module: prescale counter and timer counter.
// Produces the terminal tick and applies clear level, bus loads and the
// per-match zero/stop requests. Assumes match requests are only valid
// during a tick.
module mt_counters #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold_clr,
    input  logic [W-1:0] pr,
    input  logic         pc_wr,
    input  logic         tc_wr,
    input  logic [W-1:0] wdata,
    input  logic         match_zero,
    input  logic         match_stop,
    output logic         tick,
    output logic [W-1:0] pc,
    output logic [W-1:0] tc
);
    // Terminal tick: prescaler has reached its limit while running.
    always_comb tick = run && !hold_clr && (pc == pr);

    // Prescale counter: clear level, then bus load, then wrap or count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            pc <= '0;
        end else if (pc_wr) begin
            pc <= wdata;
        end else if (tick) begin
            pc <= '0;
        end else if (run) begin
            pc <= pc + 1'b1;
        end
    end

    // Timer counter: clear level, then bus load, then tick actions.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            tc <= '0;
        end else if (tc_wr) begin
            tc <= wdata;
        end else if (tick) begin
            if (match_zero) begin
                tc <= '0;
            end else if (!match_stop) begin
                tc <= tc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mt_match_chan.sv
// Module: one compare channel.
// Detects equality on a tick and splits the hit into the three action
// requests selected by its configuration. Purely combinational.
module mt_match_chan #(
    parameter int W = 32
) (
    input  logic           tick,
    input  logic [W-1:0]   tc,
    input  logic [W-1:0]   cmp,
    input  mt_pkg::ch_cfg_t cfg,
    output logic           hit,
    output logic           flag_req,
    output logic           zero_req,
    output logic           stop_req
);
    // Match on a tick and gate each action by its enable.
    always_comb begin
        hit      = tick && (tc == cmp);
        flag_req = hit && cfg.flag_en;
        zero_req = hit && cfg.zero_en;
        stop_req = hit && cfg.stop_en;
    end
endmodule

// File: rtl/mt_flags.sv
// Module: pending flag register with write-one-to-clear.
// A hardware set in the same cycle as a clear wins.
module mt_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // Latch sets, drop cleared bits, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end
endmodule

// File: rtl/match_timer.sv
// Module: prescaled match timer top.
// Holds the software registers, decodes the single-cycle bus and wires
// the counters, compare channels and flag register. Assumes bus_addr is
// a byte address; reads are combinational.
module match_timer #(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] match_pulse,
    output logic              irq
);
    import mt_pkg::*;

    localparam int MCTL_W = 3 * NUM_CH;
    localparam int FLAG_W = NUM_CH + 1;

    logic              en_q;
    logic              rst_q;
    logic [DATA_W-1:0] pr_q;
    logic [MCTL_W-1:0] mcr_q;
    logic [DATA_W-1:0] cmp_q [NUM_CH];
    logic [DATA_W-1:0] tc_q;
    logic [DATA_W-1:0] pc_q;
    logic [FLAG_W-1:0] flags_q;
    logic              tick;
    logic              tc_wr;
    logic              pc_wr;
    logic              ctrl_wr;
    logic              flag_wr;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] flag_req;
    logic [NUM_CH-1:0] zero_req;
    logic [NUM_CH-1:0] stop_req;
    logic [FLAG_W-1:0] flag_clr;

    // Write strobes for single registers.
    always_comb begin
        ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
        tc_wr   = bus_we && (bus_addr == ADDR_W'(OFF_TC));
        pc_wr   = bus_we && (bus_addr == ADDR_W'(OFF_PC));
        flag_wr = bus_we && (bus_addr == ADDR_W'(OFF_FLAGS));
        flag_clr = flag_wr ? bus_wdata[FLAG_W-1:0] : '0;
    end

    // Control bits: a self-stop drops the enable over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            if (|stop_req) begin
                en_q <= 1'b0;
            end else if (ctrl_wr) begin
                en_q <= bus_wdata[0];
            end
            if (ctrl_wr) begin
                rst_q <= bus_wdata[1];
            end
        end
    end

    // Prescale limit, match control and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q  <= '0;
            mcr_q <= '0;
            for (int n = 0; n < NUM_CH; n++) cmp_q[n] <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFF_PR))   pr_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_MCTL)) mcr_q <= bus_wdata[MCTL_W-1:0];
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_addr == ADDR_W'(cmp_off(n))) cmp_q[n] <= bus_wdata;
            end
        end
    end

    mt_counters #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .hold_clr   (rst_q),
        .pr         (pr_q),
        .pc_wr      (pc_wr),
        .tc_wr      (tc_wr),
        .wdata      (bus_wdata),
        .match_zero (|zero_req),
        .match_stop (|stop_req),
        .tick       (tick),
        .pc         (pc_q),
        .tc         (tc_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        mt_match_chan #(.W(DATA_W)) u_chan (
            .tick     (tick),
            .tc       (tc_q),
            .cmp      (cmp_q[g]),
            .cfg      (ch_cfg_t'(mcr_q[3*g +: 3])),
            .hit      (hit[g]),
            .flag_req (flag_req[g]),
            .zero_req (zero_req[g]),
            .stop_req (stop_req[g])
        );
    end

    mt_flags #(.N(FLAG_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({1'b0, flag_req}),
        .clr   (flag_clr),
        .flags (flags_q)
    );

    // Registered one-cycle match events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_pulse <= '0;
        end else begin
            match_pulse <= hit;
        end
    end

    // Interrupt line from pending flags.
    always_comb irq = |flags_q;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_FLAGS)) bus_rdata = DATA_W'(flags_q);
        if (bus_addr == ADDR_W'(OFF_CTRL))  bus_rdata = DATA_W'({rst_q, en_q});
        if (bus_addr == ADDR_W'(OFF_TC))    bus_rdata = tc_q;
        if (bus_addr == ADDR_W'(OFF_PR))    bus_rdata = pr_q;
        if (bus_addr == ADDR_W'(OFF_PC))    bus_rdata = pc_q;
        if (bus_addr == ADDR_W'(OFF_MCTL))  bus_rdata = DATA_W'(mcr_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(cmp_off(n))) bus_rdata = cmp_q[n];
        end
    end
endmodule

// File: rtl/mt_checker.sv
// Module: temporal checks on the match timer, bound into the top.
// Observes control state, counters, events and flags; drives nothing.
module mt_checker #(
    parameter int NUM_CH = 4,
    parameter int W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic              rst_q,
    input logic              tc_wr,
    input logic [3*NUM_CH-1:0] mcr_q,
    input logic [NUM_CH-1:0] match_pulse,
    input logic [NUM_CH:0]   flags_q,
    input logic [W-1:0]      tc_q,
    input logic [W-1:0]      pc_q
);
    AST_CLEAR_LEVEL_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> (tc_q == '0 && pc_q == '0)); // R3

    AST_TC_HOLDS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !rst_q && !tc_wr) |=> (tc_q == $past(tc_q))); // R2

    AST_EVENT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_pulse) |-> $past(en_q && !rst_q)); // R4

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (match_pulse[n] && $past(mcr_q[3*n])) |-> flags_q[n]); // R9

        AST_STOP_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            (match_pulse[n] && $past(mcr_q[3*n+2])) |-> !en_q); // R7

        AST_ZERO_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (match_pulse[n] && $past(mcr_q[3*n+1]) && !$past(tc_wr)) |-> (tc_q == '0)); // R6
    end
endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH), .W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .rst_q       (rst_q),
    .tc_wr       (tc_wr),
    .mcr_q       (mcr_q),
    .match_pulse (match_pulse),
    .flags_q     (flags_q),
    .tc_q        (tc_q),
    .pc_q        (pc_q)
);

// File: tb/tb_match_timer.sv
// Directed bench for match_timer: one task per scenario, each checks itself.
module tb_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pulse;
    logic        irq;
    int          checks = 0;
    int          fails = 0;

    localparam logic [7:0] A_FLG = 8'h00, A_CTL = 8'h04, A_TC = 8'h08,
                           A_PR = 8'h0C, A_PC = 8'h10, A_MCT = 8'h14;
    localparam logic [31:0] FAR = 32'hFFFF_0000;

    always #5 clk = ~clk;

    match_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .match_pulse(pulse), .irq(irq)
    );

    function automatic logic [7:0] a_cmp(input int n);
        return 8'h18 + 8'(4 * n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; write lands on the next posedge, returns at negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Set compare values, clear counters, then start: start edge is E0.
    task automatic setup_run(input logic [31:0] pr, input logic [31:0] mct,
                             input logic [31:0] c0, input logic [31:0] c1,
                             input logic [31:0] c2, input logic [31:0] c3);
        wr(A_CTL, 0);
        wr(A_PR, pr); wr(A_MCT, mct);
        wr(a_cmp(0), c0); wr(a_cmp(1), c1); wr(a_cmp(2), c2); wr(a_cmp(3), c3);
        wr(A_FLG, 32'h1F);
        wr(A_CTL, 2);
        wr(A_CTL, 1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_FLG, v); chk("R1 flags", v, 0);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_TC, v);  chk("R1 tc", v, 0);
        rd(A_PR, v);  chk("R1 pr", v, 0);
        rd(A_PC, v);  chk("R1 pc", v, 0);
        rd(A_MCT, v); chk("R1 mctl", v, 0);
        for (int n = 0; n < 4; n++) begin
            rd(a_cmp(n), v); chk("R1 cmp", v, 0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pulse", 32'(pulse), 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        setup_run(2, 0, FAR, FAR, FAR, FAR);
        wait_n(9);
        rd(A_TC, v); chk("R2 tc after 9", v, 3);
        rd(A_PC, v); chk("R2 pc after 9", v, 0);
        wait_n(1);
        rd(A_PC, v); chk("R2 pc step", v, 1);
        wr(A_CTL, 0);
        wait_n(5);
        rd(A_PC, v); chk("R2 pc held", v, 2);
        rd(A_TC, v); chk("R2 tc held", v, 3);
    endtask

    task automatic t_clear_level;
        logic [31:0] v;
        wr(A_CTL, 3);
        wait_n(4);
        rd(A_TC, v);  chk("R3 tc zero", v, 0);
        rd(A_PC, v);  chk("R3 pc zero", v, 0);
        rd(A_CTL, v); chk("R3 ctrl", v, 3);
        wr(A_CTL, 1);
        wait_n(3);
        rd(A_TC, v);  chk("R3 resume", v, 1);
        wr(A_CTL, 0);
    endtask

    task automatic t_zero_and_flag;
        logic [31:0] v;
        setup_run(2, 32'h3, 3, FAR, FAR, FAR);
        wait_n(11);
        chk("R4 no pulse yet", 32'(pulse), 0);
        rd(A_TC, v); chk("R6 tc before", v, 3);
        wait_n(1);
        chk("R4 pulse", 32'(pulse), 1);
        rd(A_TC, v); chk("R6 tc zero", v, 0);
        rd(A_FLG, v); chk("R5 flag", v, 1);
        chk("R5 irq", 32'(irq), 1);
        wait_n(1);
        chk("R4 one cycle", 32'(pulse), 0);
        wait_n(11);
        chk("R6 period", 32'(pulse), 1);
        wr(A_FLG, 1);
        rd(A_FLG, v); chk("R8 cleared", v, 0);
        chk("R8 irq low", 32'(irq), 0);
        wr(A_CTL, 0);
    endtask

    task automatic t_event_only;
        logic [31:0] v;
        setup_run(0, 0, FAR, 2, FAR, FAR);
        wait_n(3);
        chk("R4 event no irq", 32'(pulse), 32'h2);
        rd(A_TC, v);  chk("R4 tc continues", v, 3);
        rd(A_FLG, v); chk("R4 no flag", v, 0);
        chk("R4 irq low", 32'(irq), 0);
        wr(A_CTL, 0);
    endtask

    task automatic t_self_stop;
        logic [31:0] v;
        setup_run(0, (1 << 8) | (1 << 6), FAR, FAR, 5, FAR);
        wait_n(6);
        rd(A_CTL, v); chk("R7 enable dropped", v, 0);
        rd(A_TC, v);  chk("R7 tc frozen", v, 5);
        rd(A_FLG, v); chk("R7 flag2", v, 4);
        wait_n(3);
        rd(A_TC, v);  chk("R7 still frozen", v, 5);
        rd(A_PC, v);  chk("R7 pc frozen", v, 0);
        wr(A_FLG, 4);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        setup_run(0, 1 << 9, FAR, FAR, FAR, 4);
        wait_n(4);
        wr(A_FLG, 8);
        rd(A_FLG, v); chk("R9 set beats clear", v, 8);
        chk("R9 pulse", 32'(pulse), 8);
        wr(A_FLG, 8);
        rd(A_FLG, v); chk("R8 later clear", v, 0);
        wr(A_CTL, 0);
    endtask

    task automatic t_bus;
        logic [31:0] v;
        wr(A_MCT, 0);
        wr(A_TC, 100); wr(A_PC, 7);
        rd(A_TC, v);  chk("R10 tc rw", v, 100);
        rd(A_PC, v);  chk("R10 pc rw", v, 7);
        wr(A_MCT, 32'hFFFF_FFFF);
        rd(A_MCT, v); chk("R10 mctl width", v, 32'hFFF);
        wr(A_MCT, 0);
        wr(A_FLG, 32'hFFFF_FFFF);
        rd(A_FLG, v); chk("R10 flags reserved", v, 0);
        wr(A_CTL, 32'hFFFF_FFFC);
        rd(A_CTL, v); chk("R10 ctrl reserved", v, 0);
        wr(a_cmp(2), 32'hA5A5_0001);
        rd(a_cmp(2), v); chk("R10 cmp rw", v, 32'hA5A5_0001);
        rd(8'h40, v); chk("R10 unmapped", v, 0);
        wr(A_PR, 0); wr(A_PC, 0);
        wr(A_CTL, 1);
        wait_n(1);
        rd(A_TC, v);  chk("R10 count from loaded", v, 101);
        wr(A_CTL, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_prescale();
        t_clear_level();
        t_zero_and_flag();
        t_event_only();
        t_self_stop();
        t_set_wins();
        t_bus();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule